// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block arbitrates among seven interrupt sources: two external inputs, two timers, a serial channel, a low-voltage monitor and a two-wire bus controller. Each source has an enable bit, and a global enable gates all of them. Every priority group takes one of four levels from a pair of bits, one bit in each of two 6-bit level registers. The two-wire bus source has no level pair of its own and uses the low-voltage group's pair. Each cycle the block selects the pending, enabled request with the highest level. When several requests share that level, it picks one in a fixed polling order. It then presents a request flag, the vector address and the winning level.

A four-bit in-service bitmap, one bit per level, tracks nesting. When the CPU acknowledges a presented request, the bit for the granted level is set. A return strobe clears the highest set bit. A pending request is offered only if its level is strictly above every level still in service. When nothing is in service, any enabled level may be offered, level 0 included. The block does not cover the CPU, the way sources raise their flags, or how those flags are cleared.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, the in-service bitmap is 0000 and irqReq is low.
- R2: Register select 0 is enable A, 1 is enable B, 2 is level-low and 3 is level-high. A write lands one cycle later. Enable A keeps bits 7 and 4..0 and reads 0 in bits 6..5. Enable B keeps only bits 5..4. Each level register keeps bits 5..0. regRdData shows the selected register combinationally.
- R3: When enable A bit 7 (global) is 0, irqReq stays low whatever is pending.
- R4: Source index 0..6 is external 0, timer 0, external 1, timer 1, serial, low-voltage, two-wire bus. Sources 0..4 are enabled by enable A bits 0..4. The low-voltage source is enabled by enable B bit 4 and the two-wire bus source by enable B bit 5. A pending source that is not enabled is never offered.
- R5: For group g, the level is {level-high[g], level-low[g]}, where 00 is the lowest and 11 the highest. The offered request is the eligible source with the highest level, and irqLevel shows that level.
- R6: Among eligible sources at the same level, the one with the lowest source index wins.
- R7: The vector for sources 0..6 is 0x03, 0x0B, 0x13, 0x1B, 0x23, 0x63 and 0x6B respectively.
- R8: Groups 0..5 map to sources 0..5. The two-wire bus source (6) takes its level from group 5.
- R9: While any level is in service, a request is offered only if its level is strictly above the highest level in service.
- R10: intAck while irqReq is high sets the in-service bit of irqLevel at the next edge. intAck while irqReq is low changes nothing.
- R11: intReturn clears the highest set in-service bit at the next edge. With an empty bitmap it has no effect. If intAck and intReturn come together, the clear applies to the old bitmap and the acknowledge sets its bit afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 enable A, 1 enable B, 2 level-low, 3 level-high) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Selected register contents |
| srcPending | input | 7 | Pending flags by source index |
| intAck | input | 1 | CPU accepts the offered request |
| intReturn | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | A request is offered |
| irqVector | output | 8 | Vector address of the offered request |
| irqLevel | output | 2 | Level of the offered request |
| activeLevels | output | 4 | In-service bitmap, bit n for level n |

## Verification
A corrupted in-service bitmap shows on activeLevels at the edge after the acknowledge or return that caused it. It also shows on irqReq in the same cycle, because a request that should preempt is held back or one that should wait is offered. A wrong stored enable or level bit shows on regRdData in the cycle after the write. It then shows on irqVector or irqLevel as soon as two sources compete. The bench compares all outputs against a bench-side model every cycle, so any divergence is caught within one cycle of its cause.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
  localparam int NUM_SRC  = 7;
  localparam int NUM_GRP  = 6;
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 2;
  localparam int NUM_REG  = 1 << SEL_W;
  localparam int SRC_W    = $clog2(NUM_SRC);

  localparam logic [DATA_W-1:0] MASK_ENA = 8'h9F;
  localparam logic [DATA_W-1:0] MASK_ENB = 8'h30;
  localparam logic [DATA_W-1:0] MASK_LVL = 8'h3F;

  typedef logic [LVL_W-1:0] level_t;

  typedef struct packed {
    logic [NUM_REG-1:0] regWr;
    logic               push;
    level_t             pushLevel;
    logic               pop;
  } strobes_t;

  typedef struct packed {
    logic [DATA_W-1:0]  enA;
    logic [DATA_W-1:0]  enB;
    logic [DATA_W-1:0]  lvlLo;
    logic [DATA_W-1:0]  lvlHi;
    logic [NUM_LVL-1:0] inSvc;
  } cfg_t;

  function automatic logic [DATA_W-1:0] vectorOf(input int idx);
    if (idx < 5) return DATA_W'(8 * idx + 3);
    return DATA_W'(8'h63 + 8 * (idx - 5));
  endfunction

  function automatic int groupOf(input int idx);
    return (idx < NUM_GRP) ? idx : NUM_GRP - 1;
  endfunction
endpackage

// File: rtl/intr_prio_dp.sv
module intr_prio_dp
  import intr_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output cfg_t              cfg
);
  logic [DATA_W-1:0]  enA, enB, lvlLo, lvlHi;
  logic [NUM_LVL-1:0] inSvc, popMask, nextSvc;

  always_comb begin
    popMask = '0;
    for (int n = 0; n < NUM_LVL; n++) begin
      if (inSvc[n]) popMask = NUM_LVL'(1) << n;
    end
  end

  always_comb begin
    nextSvc = inSvc;
    if (strb.pop) nextSvc = nextSvc & ~popMask;
    if (strb.push) nextSvc[strb.pushLevel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enA   <= '0;
      enB   <= '0;
      lvlLo <= '0;
      lvlHi <= '0;
      inSvc <= '0;
    end else begin
      if (strb.regWr[0]) enA   <= wrData & MASK_ENA;
      if (strb.regWr[1]) enB   <= wrData & MASK_ENB;
      if (strb.regWr[2]) lvlLo <= wrData & MASK_LVL;
      if (strb.regWr[3]) lvlHi <= wrData & MASK_LVL;
      inSvc <= nextSvc;
    end
  end

  always_comb begin
    unique case (rdSel)
      2'd0:    rdData = enA;
      2'd1:    rdData = enB;
      2'd2:    rdData = lvlLo;
      default: rdData = lvlHi;
    endcase
  end

  assign cfg = '{enA: enA, enB: enB, lvlLo: lvlLo, lvlHi: lvlHi, inSvc: inSvc};

  p_push_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> inSvc[$past(strb.pushLevel)]);

  p_pop_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && (|inSvc)) |=>
      ($countones(inSvc) + 1 == $countones($past(inSvc))));

  p_reg_masks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enA[6:5] == 2'b00) && (enB[7:6] == 2'b00) && (enB[3:0] == 4'h0)
    && (lvlLo[7:6] == 2'b00) && (lvlHi[7:6] == 2'b00));
endmodule

// File: rtl/intr_prio_ctl.sv
module intr_prio_ctl
  import intr_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfg_t               cfg,
  input  logic               regWrEn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic               intAck,
  input  logic               intReturn,
  output strobes_t           strb,
  output logic               irqReq,
  output logic [DATA_W-1:0]  irqVector,
  output level_t             irqLevel
);
  level_t             srcLvl [NUM_SRC];
  logic [NUM_SRC-1:0] srcEn, srcElig;
  logic               anySvc;
  level_t             topSvc;
  logic               found;
  level_t             bestLvl;
  logic [SRC_W-1:0]   bestIdx;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int GRP = groupOf(i);
    assign srcLvl[i] = {cfg.lvlHi[GRP], cfg.lvlLo[GRP]};
    if (i < 5) begin : g_enA
      assign srcEn[i] = cfg.enA[i];
    end else begin : g_enB
      assign srcEn[i] = cfg.enB[i - 1];
    end
    assign srcElig[i] = srcPending[i] && srcEn[i] && cfg.enA[7]
                        && (!anySvc || (srcLvl[i] > topSvc));
  end

  always_comb begin
    anySvc = 1'b0;
    topSvc = '0;
    for (int n = 0; n < NUM_LVL; n++) begin
      if (cfg.inSvc[n]) begin
        anySvc = 1'b1;
        topSvc = level_t'(n);
      end
    end
  end

  always_comb begin
    found   = 1'b0;
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcElig[i] && (!found || srcLvl[i] > bestLvl)) begin
        found   = 1'b1;
        bestLvl = srcLvl[i];
        bestIdx = SRC_W'(i);
      end
    end
  end

  assign irqReq    = found;
  assign irqLevel  = bestLvl;
  assign irqVector = found ? vectorOf(int'(bestIdx)) : '0;

  always_comb begin
    strb           = '0;
    strb.regWr     = regWrEn ? (NUM_REG'(1) << regSel) : '0;
    strb.push      = intAck && found;
    strb.pushLevel = bestLvl;
    strb.pop       = intReturn;
  end

  p_global_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enA[7] |-> !irqReq);

  p_strict_preempt_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((cfg.inSvc >> irqLevel) == '0));

  p_vector_form_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector[2:0] == 3'd3));

  p_no_req_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (srcPending == '0) |-> !irqReq);
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
  import intr_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic               intAck,
  input  logic               intReturn,
  output logic               irqReq,
  output logic [DATA_W-1:0]  irqVector,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [NUM_LVL-1:0] activeLevels
);
  strobes_t strb;
  cfg_t     cfg;

  intr_prio_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .regWrEn(regWrEn), .regSel(regSel),
    .srcPending(srcPending), .intAck(intAck), .intReturn(intReturn),
    .strb(strb), .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel)
  );

  intr_prio_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .rdSel(regSel), .rdData(regRdData), .cfg(cfg)
  );

  assign activeLevels = cfg.inSvc;
endmodule

// File: tb/intr_prio_ctrl_bench.sv
`timescale 1ns/100ps
module intr_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [6:0] srcPending = '0;
  logic       intAck = 1'b0, intReturn = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector;
  logic [1:0] irqLevel;
  logic [3:0] activeLevels;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mReg [4];
  logic [3:0] mSvc;

  always #2.5 clk = ~clk;

  intr_prio_ctrl u_intr_prio_ctrl (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expVec(int i);
    case (i)
      0: return 8'h03; 1: return 8'h0B; 2: return 8'h13; 3: return 8'h1B;
      4: return 8'h23; 5: return 8'h63; default: return 8'h6B;
    endcase
  endfunction

  function automatic logic [7:0] maskOf(int s);
    case (s)
      0: return 8'h9F; 1: return 8'h30; default: return 8'h3F;
    endcase
  endfunction

  // model: expected offered request from bench-held state (R3..R9)
  function automatic void predict(input logic [6:0] p, output bit req,
                                  output logic [7:0] vec, output logic [1:0] lvl);
    int top = -1;
    int g;
    bit en;
    logic [1:0] l;
    req = 0; vec = 0; lvl = 0;
    for (int n = 0; n < 4; n++) if (mSvc[n]) top = n;
    for (int i = 0; i < 7; i++) begin
      g  = (i == 6) ? 5 : i;
      l  = {mReg[3][g], mReg[2][g]};
      en = (i < 5) ? mReg[0][i] : (i == 5 ? mReg[1][4] : mReg[1][5]);
      if (p[i] && en && mReg[0][7] && int'(l) > top && (!req || l > lvl)) begin
        req = 1; lvl = l; vec = expVec(i);
      end
    end
  endfunction

  task automatic step(bit wr, logic [1:0] sel, logic [7:0] d, logic [6:0] p,
                      bit ack, bit ret);
    bit eReq; logic [7:0] eVec; logic [1:0] eLvl;
    logic [7:0] nReg [4]; logic [3:0] nSvc;
    @(negedge clk);
    regWrEn = wr; regSel = sel; regWrData = d; srcPending = p;
    intAck = ack; intReturn = ret;
    #1;
    predict(p, eReq, eVec, eLvl);
    chk(irqReq == eReq, "R3/R4/R9 irqReq", irqReq, eReq);
    if (eReq) begin
      chk(irqVector == eVec, "R5/R6/R7/R8 irqVector", irqVector, eVec);
      chk(irqLevel == eLvl, "R5 irqLevel", irqLevel, eLvl);
    end
    chk(activeLevels == mSvc, "R10/R11 activeLevels", activeLevels, mSvc);
    chk(regRdData == mReg[sel], "R2 readback", regRdData, mReg[sel]);
    nReg = mReg; nSvc = mSvc;
    if (wr) nReg[sel] = d & maskOf(sel);
    if (ret) for (int n = 3; n >= 0; n--) if (nSvc[n]) begin nSvc[n] = 0; break; end
    if (ack && eReq) nSvc[eLvl] = 1'b1;
    @(posedge clk);
    mReg = nReg; mSvc = nSvc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 4; s++) mReg[s] = 8'h00;
    mSvc = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(irqReq == 1'b0, "R1 irqReq after reset", irqReq, 0);
    chk(activeLevels == 4'h0, "R1 activeLevels after reset", activeLevels, 0);
    @(negedge clk); rstN = 1'b1;
    for (int s = 0; s < 4; s++) step(0, 2'(s), 8'h00, 7'h00, 0, 0);
    // R2 masks
    step(1, 2'd0, 8'hFF, 7'h00, 0, 0);
    step(1, 2'd1, 8'hFF, 7'h00, 0, 0);
    step(0, 2'd0, 8'h00, 7'h00, 0, 0);
    chk(regRdData == 8'h9F, "R2 enable A mask", regRdData, 8'h9F);
    step(0, 2'd1, 8'h00, 7'h00, 0, 0);
    chk(regRdData == 8'h30, "R2 enable B mask", regRdData, 8'h30);
    // R6 tie at level 0: all pending, external 0 wins
    step(0, 2'd0, 8'h00, 7'h7F, 0, 0);
    chk(irqVector == 8'h03, "R6 tie order ext0", irqVector, 8'h03);
    // R8 group 5 to level 3: low-voltage before two-wire
    step(1, 2'd2, 8'h20, 7'h7F, 0, 0);
    step(1, 2'd3, 8'h20, 7'h60, 0, 0);
    chk(irqVector == 8'h63 && irqLevel == 2'd1, "R8 shared group lvl1", irqVector, 8'h63);
    step(1, 2'd1, 8'h20, 7'h60, 0, 0);
    step(0, 2'd1, 8'h00, 7'h60, 0, 0);
    chk(irqVector == 8'h6B && irqLevel == 2'd3, "R4/R7/R8 two-wire vector", irqVector, 8'h6B);
    // R10 ack at level 3, then nothing can preempt (R9)
    step(0, 2'd0, 8'h00, 7'h60, 1, 0);
    step(0, 2'd0, 8'h00, 7'h7F, 0, 0);
    chk(activeLevels == 4'h8 && !irqReq, "R9/R10 level 3 blocks", activeLevels, 4'h8);
    // R11 return clears, then empty return is harmless
    step(0, 2'd0, 8'h00, 7'h00, 0, 1);
    step(0, 2'd0, 8'h00, 7'h00, 0, 1);
    step(0, 2'd0, 8'h00, 7'h00, 0, 0);
    chk(activeLevels == 4'h0, "R11 empty return", activeLevels, 0);
    // R10 ack without request ignored
    step(0, 2'd0, 8'h00, 7'h00, 1, 0);
    step(0, 2'd0, 8'h00, 7'h00, 0, 0);
    chk(activeLevels == 4'h0, "R10 ack ignored", activeLevels, 0);
    // R3 global enable off
    step(1, 2'd0, 8'h1F, 7'h7F, 0, 0);
    step(0, 2'd0, 8'h00, 7'h7F, 0, 0);
    chk(!irqReq, "R3 global off", irqReq, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit wr = ($urandom % 8) == 0;
      logic [1:0] sel = 2'($urandom);
      logic [7:0] d = 8'($urandom);
      if (sel == 2'd0 && ($urandom % 4) != 0) d[7] = 1'b1;
      step(wr, sel, d, 7'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule